// File: doc/BRIEF.md
# LCD Frame and Palette Load Sequencer

This block is the control and status core of a simple raster LCD controller. Software writes one control word that holds a run bit, four interrupt-enable bits and a two-bit load-mode field. Setting the run bit starts a fetch sequence on a valid/ready word stream. The sequence is one of three: a palette block only, frame data only, or a palette block followed by continuous frames. Palette words are split into 16-bit entries and stored in an internal 256-entry RAM, which the pixel path reads through a separate port. The format code carried by the first entry is brought out to that path.

Four sticky status flags report progress and faults: end-of-run, palette captured, FIFO underflow and sync lost. The interrupt line is the OR of each flag masked by its enable bit. Clearing the run bit does not cut off a frame. The fetch finishes the frame in progress, then stops and reports end-of-run. Each flag has its own clearing rule. Some clear on a write-one, some when the sequencer stops, and the end-of-run flag clears when the block is restarted.

Top module: `lcd_load_seq`

## Requirements
- R1: After reset, all four status bits, `irq`, `wd_ready` and `busy` are 0.
- R2: A control write that changes bit 0 (run) from 0 to 1 starts a sequence chosen by bits 21:20. 2'b01 fetches a palette only, 2'b10 fetches frames only, and 2'b00 fetches a palette followed by frames. Control bits 4:1 are the interrupt enables for status bits 0 to 3.
- R3: The palette length is set by bits 14:12 of the first palette word. Code 4 (12/16 bpp) means 16 entries (8 words). Codes 0, 1, 2 and 3 (1, 2, 4 and 8 bpp) mean 256 entries (128 words). `pal_fmt` shows the captured code.
- R4: The low half of palette word k is stored as entry 2k and the high half as entry 2k+1. `pal_rdata` returns the entry at `pal_raddr` one cycle later.
- R5: Status bit 1 (palette captured) sets when the last palette word is accepted. In palette-only mode, `wd_ready` then stays 0 until the run bit is cleared, and clearing the run bit then makes `busy` fall.
- R6: A frame is FRAME_WORDS words. Frames repeat back to back while the run bit is 1.
- R7: After the run bit is cleared during the frame phase, words are still accepted until the current frame ends. `busy` then falls. Status bit 0 (end-of-run) sets at that point only if its enable is 1.
- R8: Status bit 0 ignores write-one. It clears only on a 0-to-1 change of the run bit.
- R9: A write-one clears status bit 1 only when the mode field is 2'b01. In other modes the bit stays set until the sequencer stops.
- R10: While busy, `fuf_evt` sets status bit 2 and `sync_evt` sets status bit 3. Both bits ignore write-one and clear when the sequencer stops.
- R11: `irq` is 1 exactly when some status bit and its enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word: bit 0 run, 4:1 enables, 21:20 mode |
| stat_we | input | 1 | Status write-one-to-clear strobe |
| stat_wdata | input | 4 | Status bits to clear |
| fuf_evt | input | 1 | FIFO underflow event from the pixel path |
| sync_evt | input | 1 | Sync lost event from the pixel path |
| wd_valid | input | 1 | Fetch word valid |
| wd_data | input | 32 | Fetch word |
| wd_ready | output | 1 | Sequencer accepts a word |
| busy | output | 1 | A sequence is running |
| stat | output | 4 | Status: 0 end-of-run, 1 palette, 2 underflow, 3 sync lost |
| irq | output | 1 | Interrupt request |
| pal_fmt | output | 3 | Format code from palette entry 0 |
| pal_raddr | input | 8 | Palette read address |
| pal_rdata | output | 16 | Palette entry, one cycle after address |

## Verification
The sequencer is driven in all three load modes, and each run separates a different path. A palette-only run with the 8 bpp code checks that the block counts the full 128 words and then stops accepting. A palette-plus-frame run with the 16 bpp code checks the short 8-word palette and the handover into the frame phase, where a write-one to the palette flag must be ignored. A frame-only run with every enable off checks that no palette flag appears, that end-of-run stays clear, and that a set fault flag leaves `irq` low. The late-disable sequence checks that `busy` and `wd_ready` stay high through the last word of the frame and drop only after it.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_PAL   = 2'd1,
    SQ_FRAME = 2'd2,
    SQ_HOLD  = 2'd3
  } sq_state_e;

  localparam logic [1:0] LM_BOTH  = 2'b00;
  localparam logic [1:0] LM_PAL   = 2'b01;
  localparam logic [1:0] LM_FRAME = 2'b10;

  localparam int ST_DONE = 0;
  localparam int ST_PAL  = 1;
  localparam int ST_FUF  = 2;
  localparam int ST_SYNC = 3;

  localparam int PAL_ENTRIES = 256;
  localparam int PAL_SMALL   = 16;
  localparam int PAL_AW      = $clog2(PAL_ENTRIES);
  localparam int PAL_WW      = PAL_AW - 1;

  localparam logic [2:0] FMT_WIDE = 3'd4;

  // index of the last 32-bit palette word for a given format code
  function automatic logic [PAL_WW-1:0] pal_last_word(input logic [2:0] fmt);
    if (fmt == FMT_WIDE) return PAL_WW'(PAL_SMALL / 2 - 1);
    return PAL_WW'(PAL_ENTRIES / 2 - 1);
  endfunction

endpackage

// File: rtl/lcdseq_regs.sv
module lcdseq_regs
  import lcdseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_we,
  input  logic [31:0] ctrl_wdata,
  input  logic        stat_we,
  input  logic [3:0]  stat_wdata,
  input  logic        fuf_evt,
  input  logic        sync_evt,
  input  logic        busy,
  input  logic        evt_pal_loaded,
  input  logic        evt_stop,
  input  logic        evt_drained,
  output logic        en_q,
  output logic        start,
  output logic [1:0]  start_mode,
  output logic [3:0]  stat_q,
  output logic        irq
);

  logic [3:0] ie_q;
  logic [1:0] mode_q;
  logic [3:0] stat_nxt;
  logic       unused_ctrl;

  assign unused_ctrl = ^{ctrl_wdata[31:22], ctrl_wdata[19:5]};
  assign start       = ctrl_we && ctrl_wdata[0] && !en_q;
  assign start_mode  = ctrl_wdata[21:20];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ie_q   <= '0;
      mode_q <= LM_BOTH;
    end else if (ctrl_we) begin
      en_q   <= ctrl_wdata[0];
      ie_q   <= ctrl_wdata[4:1];
      mode_q <= ctrl_wdata[21:20];
    end
  end

  always_comb begin
    stat_nxt = stat_q;
    if (stat_we && stat_wdata[ST_PAL] && mode_q == LM_PAL) stat_nxt[ST_PAL] = 1'b0;
    if (start) stat_nxt[ST_DONE] = 1'b0;
    if (busy && fuf_evt)  stat_nxt[ST_FUF]  = 1'b1;
    if (busy && sync_evt) stat_nxt[ST_SYNC] = 1'b1;
    if (evt_pal_loaded)   stat_nxt[ST_PAL]  = 1'b1;
    if (evt_stop) begin
      stat_nxt[ST_PAL]  = 1'b0;
      stat_nxt[ST_FUF]  = 1'b0;
      stat_nxt[ST_SYNC] = 1'b0;
    end
    if (evt_drained && ie_q[ST_DONE]) stat_nxt[ST_DONE] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_nxt;
  end

  assign irq = |(stat_q & ie_q);

  // R8: a write-one to end-of-run never clears it
  a_r8_done_w1c_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_we && stat_wdata[ST_DONE] && stat_q[ST_DONE] && !start) |=> stat_q[ST_DONE]);

  // R8: restarting always leaves end-of-run clear
  a_r8_done_clears_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !stat_q[ST_DONE]);

  // R7: end-of-run only appears when its enable is set
  a_r7_done_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[ST_DONE]) |-> ie_q[ST_DONE]);

  // R10: stopping wipes the palette and fault flags
  a_r10_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stop |=> (stat_q[3:1] == 3'b000));

endmodule

// File: rtl/lcdseq_fetch.sv
module lcdseq_fetch
  import lcdseq_pkg::*;
#(
  parameter int FRAME_WORDS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        start_mode,
  input  logic              en_q,
  input  logic              wd_valid,
  input  logic [2:0]        wd_fmt,
  output logic              wd_ready,
  output logic              busy,
  output logic              evt_pal_loaded,
  output logic              evt_stop,
  output logic              evt_drained,
  output logic              pal_we,
  output logic [PAL_WW-1:0] pal_widx,
  output logic [2:0]        fmt_q
);

  localparam int FCW = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1;
  localparam logic [FCW-1:0] FRM_LAST = FCW'(FRAME_WORDS - 1);

  sq_state_e         state;
  logic [1:0]        run_mode;
  logic [PAL_WW-1:0] pal_cnt;
  logic [FCW-1:0]    frm_cnt;
  logic              accept;
  logic [2:0]        fmt_now;
  logic              pal_last;
  logic              frm_last;
  logic              keep_running;

  assign wd_ready     = (state == SQ_PAL) || (state == SQ_FRAME);
  assign busy         = (state != SQ_IDLE);
  assign accept       = wd_valid && wd_ready;
  assign fmt_now      = (pal_cnt == '0) ? wd_fmt : fmt_q;
  assign pal_last     = accept && (state == SQ_PAL) && (pal_cnt == pal_last_word(fmt_now));
  assign frm_last     = accept && (state == SQ_FRAME) && (frm_cnt == FRM_LAST);
  assign keep_running = en_q || start;

  assign evt_pal_loaded = pal_last;
  assign evt_drained    = frm_last && !keep_running;
  assign evt_stop       = evt_drained || ((state == SQ_HOLD) && !en_q);
  assign pal_we         = accept && (state == SQ_PAL);
  assign pal_widx       = pal_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      run_mode <= LM_BOTH;
      pal_cnt  <= '0;
      frm_cnt  <= '0;
      fmt_q    <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: if (start) begin
          run_mode <= start_mode;
          pal_cnt  <= '0;
          frm_cnt  <= '0;
          state    <= (start_mode == LM_FRAME) ? SQ_FRAME : SQ_PAL;
        end
        SQ_PAL: if (accept) begin
          if (pal_cnt == '0) fmt_q <= wd_fmt;
          if (pal_last) begin
            pal_cnt <= '0;
            frm_cnt <= '0;
            state   <= (run_mode == LM_PAL) ? SQ_HOLD : SQ_FRAME;
          end else begin
            pal_cnt <= pal_cnt + 1'b1;
          end
        end
        SQ_FRAME: if (accept) begin
          if (frm_last) begin
            frm_cnt <= '0;
            if (!keep_running) state <= SQ_IDLE;
          end else begin
            frm_cnt <= frm_cnt + 1'b1;
          end
        end
        SQ_HOLD: if (!en_q) state <= SQ_IDLE;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R7: the sequencer only stops once the run bit is gone
  a_r7_stop_only_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stop |-> !en_q);

  // R3: a palette ends after 8 or 128 words, nothing else
  a_r3_pal_length: assert property (@(posedge clk) disable iff (!rst_n)
    pal_last |-> (pal_cnt == PAL_WW'(PAL_SMALL/2 - 1) || pal_cnt == PAL_WW'(PAL_ENTRIES/2 - 1)));

  // R5: palette-only runs stop taking words after the palette
  a_r5_hold_after_palette: assert property (@(posedge clk) disable iff (!rst_n)
    (pal_last && run_mode == LM_PAL) |=> !wd_ready);

  // R6: while running, the last frame word leads straight into another frame
  a_r6_frame_repeats: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_last && keep_running) |=> (wd_ready && busy));

endmodule

// File: rtl/lcdseq_pal_ram.sv
module lcdseq_pal_ram #(
  parameter int ENTRIES = 256,
  localparam int AW = $clog2(ENTRIES),
  localparam int WW = AW - 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [WW-1:0] widx,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [15:0]   rdata
);

  logic [15:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[{widx, 1'b0}] <= wdata[15:0];
      mem[{widx, 1'b1}] <= wdata[31:16];
    end
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/lcd_load_seq.sv
module lcd_load_seq
  import lcdseq_pkg::*;
#(
  parameter int FRAME_WORDS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_we,
  input  logic [31:0] ctrl_wdata,
  input  logic        stat_we,
  input  logic [3:0]  stat_wdata,
  input  logic        fuf_evt,
  input  logic        sync_evt,
  input  logic        wd_valid,
  input  logic [31:0] wd_data,
  output logic        wd_ready,
  output logic        busy,
  output logic [3:0]  stat,
  output logic        irq,
  output logic [2:0]  pal_fmt,
  input  logic [7:0]  pal_raddr,
  output logic [15:0] pal_rdata
);

  logic              en_q;
  logic              start;
  logic [1:0]        start_mode;
  logic              evt_pal_loaded;
  logic              evt_stop;
  logic              evt_drained;
  logic              pal_we;
  logic [PAL_WW-1:0] pal_widx;

  lcdseq_regs u_regs (
    .clk            (clk),
    .rst_n          (rst_n),
    .ctrl_we        (ctrl_we),
    .ctrl_wdata     (ctrl_wdata),
    .stat_we        (stat_we),
    .stat_wdata     (stat_wdata),
    .fuf_evt        (fuf_evt),
    .sync_evt       (sync_evt),
    .busy           (busy),
    .evt_pal_loaded (evt_pal_loaded),
    .evt_stop       (evt_stop),
    .evt_drained    (evt_drained),
    .en_q           (en_q),
    .start          (start),
    .start_mode     (start_mode),
    .stat_q         (stat),
    .irq            (irq)
  );

  lcdseq_fetch #(.FRAME_WORDS(FRAME_WORDS)) u_fetch (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .start_mode     (start_mode),
    .en_q           (en_q),
    .wd_valid       (wd_valid),
    .wd_fmt         (wd_data[14:12]),
    .wd_ready       (wd_ready),
    .busy           (busy),
    .evt_pal_loaded (evt_pal_loaded),
    .evt_stop       (evt_stop),
    .evt_drained    (evt_drained),
    .pal_we         (pal_we),
    .pal_widx       (pal_widx),
    .fmt_q          (pal_fmt)
  );

  lcdseq_pal_ram #(.ENTRIES(PAL_ENTRIES)) u_pal (
    .clk   (clk),
    .we    (pal_we),
    .widx  (pal_widx),
    .wdata (wd_data),
    .raddr (pal_raddr),
    .rdata (pal_rdata)
  );

endmodule

// File: tb/tb_lcd_load_seq.sv
`timescale 1ns/1ps
module tb_lcd_load_seq;

  localparam int FW = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [31:0] ctrl_wdata = '0;
  logic        stat_we = 1'b0;
  logic [3:0]  stat_wdata = '0;
  logic        fuf_evt = 1'b0;
  logic        sync_evt = 1'b0;
  logic        wd_valid = 1'b0;
  logic [31:0] wd_data = '0;
  logic        wd_ready, busy, irq;
  logic [3:0]  stat;
  logic [2:0]  pal_fmt;
  logic [7:0]  pal_raddr = '0;
  logic [15:0] pal_rdata;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  lcd_load_seq #(.FRAME_WORDS(FW)) dut (.*);

  function automatic logic [31:0] ctl(input logic en, input logic [3:0] ie, input logic [1:0] mode);
    return {10'b0, mode, 15'b0, ie, en};
  endfunction

  function automatic logic [15:0] entry(input int e);
    return 16'(((e * 37) + 5) & 12'hFFF);
  endfunction

  function automatic logic [31:0] pal_word(input int k, input logic [2:0] fmt);
    logic [15:0] lo;
    lo = entry(2*k);
    if (k == 0) lo = lo | {1'b0, fmt, 12'h000};
    return {entry(2*k+1), lo};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [31:0] d);
    ctrl_we = 1'b1; ctrl_wdata = d;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic w1c(input logic [3:0] d);
    stat_we = 1'b1; stat_wdata = d;
    @(negedge clk);
    stat_we = 1'b0;
  endtask

  task automatic push_word(input logic [31:0] d);
    while (!wd_ready) @(negedge clk);
    wd_valid = 1'b1; wd_data = d;
    @(negedge clk);
    wd_valid = 1'b0;
  endtask

  task automatic read_entry(input int e, input logic [15:0] exp, input string req);
    pal_raddr = 8'(e);
    @(negedge clk);
    chk(req, {16'h0, pal_rdata}, {16'h0, exp});
  endtask

  task automatic t_reset();
    chk("R1 stat", {28'h0, stat}, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 ready", {31'h0, wd_ready}, 32'h0);
    chk("R1 busy", {31'h0, busy}, 32'h0);
  endtask

  task automatic t_palette_only();
    wr_ctrl(ctl(1'b1, 4'b0010, 2'b01));
    chk("R2 pal-only ready", {31'h0, wd_ready}, 32'h1);
    for (int k = 0; k < 127; k++) push_word(pal_word(k, 3'd3));
    chk("R3 not yet loaded", {31'h0, stat[1]}, 32'h0);
    chk("R3 still ready", {31'h0, wd_ready}, 32'h1);
    push_word(pal_word(127, 3'd3));
    chk("R5 pal flag", {31'h0, stat[1]}, 32'h1);
    chk("R5 hold no ready", {31'h0, wd_ready}, 32'h0);
    chk("R11 irq pal", {31'h0, irq}, 32'h1);
    chk("R3 fmt", {29'h0, pal_fmt}, 32'h3);
    read_entry(0, entry(0) | 16'h3000, "R4 entry0");
    read_entry(5, entry(5), "R4 entry5");
    read_entry(255, entry(255), "R4 entry255");
    w1c(4'b0010);
    chk("R9 w1c pal-only", {31'h0, stat[1]}, 32'h0);
    chk("R11 irq clears", {31'h0, irq}, 32'h0);
    wr_ctrl(ctl(1'b0, 4'b0010, 2'b01));
    chk("R5 busy after hold", {31'h0, busy}, 32'h1);
    @(negedge clk);
    chk("R5 stop", {31'h0, busy}, 32'h0);
    chk("R5 done stays 0", {31'h0, stat[0]}, 32'h0);
  endtask

  task automatic t_pal_and_frame();
    wr_ctrl(ctl(1'b1, 4'b0101, 2'b00));
    for (int k = 0; k < 8; k++) push_word(pal_word(k, 3'd4));
    chk("R3 short palette", {31'h0, stat[1]}, 32'h1);
    chk("R2 into frame", {31'h0, wd_ready}, 32'h1);
    chk("R3 fmt wide", {29'h0, pal_fmt}, 32'h4);
    w1c(4'b0010);
    chk("R9 w1c ignored", {31'h0, stat[1]}, 32'h1);
    for (int i = 0; i < 2*FW; i++) push_word(32'hF000_0000 + 32'(i));
    chk("R6 repeats busy", {31'h0, busy}, 32'h1);
    chk("R6 repeats ready", {31'h0, wd_ready}, 32'h1);
    chk("R6 no done", {31'h0, stat[0]}, 32'h0);
    fuf_evt = 1'b1; @(negedge clk); fuf_evt = 1'b0;
    chk("R10 fuf set", {31'h0, stat[2]}, 32'h1);
    chk("R11 irq fuf", {31'h0, irq}, 32'h1);
    w1c(4'b0100);
    chk("R10 fuf w1c ignored", {31'h0, stat[2]}, 32'h1);
    push_word(32'hA5A5_0000);
    wr_ctrl(ctl(1'b0, 4'b0101, 2'b00));
    for (int i = 1; i < FW-1; i++) push_word(32'hA5A5_0000 + 32'(i));
    chk("R7 still busy", {31'h0, busy}, 32'h1);
    chk("R7 still ready", {31'h0, wd_ready}, 32'h1);
    chk("R7 done not yet", {31'h0, stat[0]}, 32'h0);
    push_word(32'hA5A5_FFFF);
    chk("R7 stopped", {31'h0, busy}, 32'h0);
    chk("R7 done set", {31'h0, stat[0]}, 32'h1);
    chk("R10 cleared on stop", {29'h0, stat[3:1]}, 32'h0);
    chk("R11 irq done", {31'h0, irq}, 32'h1);
    chk("R7 idle no ready", {31'h0, wd_ready}, 32'h0);
    w1c(4'b0001);
    chk("R8 done w1c ignored", {31'h0, stat[0]}, 32'h1);
  endtask

  task automatic t_frame_only();
    wr_ctrl(ctl(1'b1, 4'b0000, 2'b10));
    chk("R8 done cleared on start", {31'h0, stat[0]}, 32'h0);
    chk("R2 frame-only ready", {31'h0, wd_ready}, 32'h1);
    for (int i = 0; i < FW; i++) push_word(32'h1234_0000 + 32'(i));
    chk("R2 no palette flag", {31'h0, stat[1]}, 32'h0);
    sync_evt = 1'b1; @(negedge clk); sync_evt = 1'b0;
    chk("R10 sync set", {31'h0, stat[3]}, 32'h1);
    chk("R11 masked irq", {31'h0, irq}, 32'h0);
    w1c(4'b1000);
    chk("R10 sync w1c ignored", {31'h0, stat[3]}, 32'h1);
    wr_ctrl(ctl(1'b0, 4'b0000, 2'b10));
    for (int i = 0; i < FW; i++) push_word(32'h5678_0000 + 32'(i));
    chk("R7 stopped no ie", {31'h0, busy}, 32'h0);
    chk("R7 done needs ie", {31'h0, stat[0]}, 32'h0);
    chk("R10 sync cleared", {31'h0, stat[3]}, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_palette_only();
    t_pal_and_frame();
    t_frame_only();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule